// File: doc/BRIEF.md
# Byte-Lane Access Splitter for a Two-Bank 16-Bit Memory

This block sits between a core that issues 8-bit or 16-bit loads and stores at any byte address and a 16-bit memory built from two byte-wide banks: an even bank that holds every even byte address and an odd bank that holds every odd byte address. For each core access it works out the word address, the active-low high-bank enable and the low address bit for each bus cycle. It places write bytes on the correct lanes and gathers read bytes back into a result whose first byte sits in the low bits.

A 16-bit access that starts on an even address takes one bus cycle with both banks enabled. A 16-bit access that starts on an odd address straddles two words. It is carried out as two single-bank bus cycles: first the odd lane of the starting word, then the even lane of the next word. The core side is a single-cycle request pulse answered by a single-cycle done pulse. The memory side is a level request held until a bus cycle engine returns a done pulse.

Top module: `lane_splitter`

## Requirements
- R1: While reset is held and on the cycle after it is released, `bus_req` and `core_done` are 0.
- R2: An 8-bit access at an even address makes one bus cycle with `bus_bhe_n`=1, `bus_a0`=0, `bus_waddr` = address divided by two, and for a write `bus_wdata` = the write byte on both lanes.
- R3: An 8-bit access at an odd address makes one bus cycle with `bus_bhe_n`=0, `bus_a0`=1, `bus_waddr` = address divided by two, and for a write the write byte on both lanes, so that it appears on bits 15:8.
- R4: A 16-bit access at an even address makes one bus cycle with `bus_bhe_n`=0, `bus_a0`=0 and `bus_wdata` equal to `core_wdata` unchanged.
- R5: A 16-bit access at an odd address makes two bus cycles. The first has `bus_bhe_n`=0, `bus_a0`=1 at address/2 and carries the low write byte. The second has `bus_bhe_n`=1, `bus_a0`=0 at address/2 + 1 and carries the high write byte. Each write byte is placed on both lanes.
- R6: The second word address of a split access wraps modulo 2^(AW-1): an odd access in the top word continues at word 0.
- R7: A byte read returns its byte in `core_rdata[7:0]` with bits 15:8 zero. An odd-lane byte is taken from `bus_rdata[15:8]`. An aligned 16-bit read returns `bus_rdata` unchanged.
- R8: A split 16-bit read returns {second cycle `bus_rdata[7:0]`, first cycle `bus_rdata[15:8]`}.
- R9: `bus_req` rises on the clock after an accepted `core_req`. While `bus_req` is high and `bus_done` is low, `bus_req`, `bus_wr`, `bus_waddr` and the lane selects keep their values. A split access moves to its second cycle on the clock after the first `bus_done`.
- R10: `core_done` is a one-cycle pulse on the clock after the last `bus_done` of an access. No pulse appears between the two cycles of a split access.
- R11: `core_req` is accepted only while no access is in progress (including the done cycle). A request at any other time has no effect on the bus outputs or the result.
- R12: The lane code `bus_bhe_n`=1 with `bus_a0`=1 is never issued while `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | One-cycle access request from the core |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| core_addr | input | AW | Byte address |
| core_wdata | input | 2*BW | Write data, low byte first |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | 2*BW | Read result aligned to the low byte, valid with `core_done` |
| bus_req | output | 1 | Bus cycle request, held until `bus_done` |
| bus_wr | output | 1 | Bus cycle direction |
| bus_waddr | output | AW-1 | Word address |
| bus_bhe_n | output | 1 | Odd (high) bank enable, active low |
| bus_a0 | output | 1 | Low address bit; 0 enables the even bank |
| bus_wdata | output | 2*BW | Lane-placed write data |
| bus_done | input | 1 | Bus cycle completion pulse |
| bus_rdata | input | 2*BW | Word read from both banks, valid with `bus_done` |

## Verification
The hardest situations to reach are the ones inside a split access. These are a second request arriving while the first of two bus cycles is still stretched by wait states, and an odd 16-bit access in the very last word, whose second cycle must wrap to word zero. The stimulus sets the bus engine's latency for each access from zero to three cycles. It injects a stray request two cycles after a split begins and places accesses at the highest byte addresses. Read words are a function of the word address, so a result built from the wrong word or the wrong byte order shows up as a changed value.

// File: rtl/lane_splitter_pkg.sv
package lane_splitter_pkg;

    // Lane select pair as driven on the bus: active-low high-bank enable, low address bit
    typedef struct packed {
        logic bhe_n;
        logic a0;
    } lane_t;

    localparam lane_t LANE_BOTH = '{bhe_n: 1'b0, a0: 1'b0};
    localparam lane_t LANE_ODD  = '{bhe_n: 1'b0, a0: 1'b1};
    localparam lane_t LANE_EVEN = '{bhe_n: 1'b1, a0: 1'b0};

    // Shape of an accepted core access
    typedef enum logic [1:0] {
        K_BYTE_EVEN  = 2'd0,
        K_BYTE_ODD   = 2'd1,
        K_WORD_ALIGN = 2'd2,
        K_WORD_SPLIT = 2'd3
    } kind_t;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_RESP   = 2'd3
    } seq_st_t;

    function automatic kind_t classify(input logic wide, input logic odd);
        kind_t k;
        case ({wide, odd})
            2'b00:   k = K_BYTE_EVEN;
            2'b01:   k = K_BYTE_ODD;
            2'b10:   k = K_WORD_ALIGN;
            default: k = K_WORD_SPLIT;
        endcase
        return k;
    endfunction

    function automatic lane_t lanes_for(input kind_t k, input logic second);
        lane_t l;
        case (k)
            K_BYTE_EVEN:  l = LANE_EVEN;
            K_BYTE_ODD:   l = LANE_ODD;
            K_WORD_ALIGN: l = LANE_BOTH;
            default:      l = second ? LANE_EVEN : LANE_ODD;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/lane_splitter_decode.sv
module lane_splitter_decode
    import lane_splitter_pkg::*;
#(
    parameter int AW = 20,
    parameter int BW = 8,
    localparam int WAW = AW - 1,
    localparam int DW  = 2 * BW
) (
    input  kind_t           kind,
    input  logic [WAW-1:0]  word_addr,
    input  logic [DW-1:0]   wdata,
    input  logic            second,
    output logic [WAW-1:0]  bus_waddr,
    output lane_t           lanes,
    output logic [DW-1:0]   bus_wdata
);
    logic [BW-1:0] lane_byte [2];
    logic [BW-1:0] pick;

    // Split the write word into its two bytes
    for (genvar g = 0; g < 2; g++) begin : g_bytes
        assign lane_byte[g] = wdata[g*BW +: BW];
    end

    always_comb begin
        // The second cycle of a split access moves to the next word (wraps at the top)
        bus_waddr = word_addr + WAW'(second);
        lanes     = lanes_for(kind, second);
        pick      = (kind == K_WORD_SPLIT && second) ? lane_byte[1] : lane_byte[0];
        if (kind == K_WORD_ALIGN) begin
            bus_wdata = wdata;
        end else begin
            bus_wdata = {pick, pick};
        end
    end
endmodule

// File: rtl/lane_splitter_seq.sv
module lane_splitter_seq
    import lane_splitter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic core_req,
    input  logic bus_done,
    input  logic is_split,
    output logic accept,
    output logic in_second,
    output logic bus_req,
    output logic resp,
    output logic first_done,
    output logic last_done
);
    seq_st_t st, st_nx;

    always_comb begin
        accept     = (st == ST_IDLE) && core_req;
        bus_req    = (st == ST_FIRST) || (st == ST_SECOND);
        in_second  = (st == ST_SECOND);
        resp       = (st == ST_RESP);
        first_done = (st == ST_FIRST) && bus_done;
        last_done  = bus_done && (((st == ST_FIRST) && !is_split) || (st == ST_SECOND));
        st_nx      = st;
        case (st)
            ST_IDLE:   if (core_req) st_nx = ST_FIRST;
            ST_FIRST:  if (bus_done) st_nx = is_split ? ST_SECOND : ST_RESP;
            ST_SECOND: if (bus_done) st_nx = ST_RESP;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end
endmodule

// File: rtl/lane_splitter_merge.sv
module lane_splitter_merge
    import lane_splitter_pkg::*;
#(
    parameter int BW = 8,
    localparam int DW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  kind_t         kind,
    input  logic          first_done,
    input  logic          last_done,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] result
);
    logic [BW-1:0] held_lo;
    logic [BW-1:0] rd_even;
    logic [BW-1:0] rd_odd;
    logic [DW-1:0] assembled;

    assign rd_even = bus_rdata[BW-1:0];
    assign rd_odd  = bus_rdata[DW-1:BW];

    always_comb begin
        case (kind)
            K_BYTE_EVEN:  assembled = {{BW{1'b0}}, rd_even};
            K_BYTE_ODD:   assembled = {{BW{1'b0}}, rd_odd};
            K_WORD_ALIGN: assembled = bus_rdata;
            default:      assembled = {rd_even, held_lo};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_lo <= '0;
            result  <= '0;
        end else begin
            // The first half of a split read comes through the odd lane
            if (first_done && kind == K_WORD_SPLIT) held_lo <= rd_odd;
            if (last_done) result <= assembled;
        end
    end
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
    import lane_splitter_pkg::*;
#(
    parameter int AW = 20,
    parameter int BW = 8,
    localparam int WAW = AW - 1,
    localparam int DW  = 2 * BW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           core_req,
    input  logic           core_wr,
    input  logic           core_wide,
    input  logic [AW-1:0]  core_addr,
    input  logic [DW-1:0]  core_wdata,
    output logic           core_done,
    output logic [DW-1:0]  core_rdata,
    output logic           bus_req,
    output logic           bus_wr,
    output logic [WAW-1:0] bus_waddr,
    output logic           bus_bhe_n,
    output logic           bus_a0,
    output logic [DW-1:0]  bus_wdata,
    input  logic           bus_done,
    input  logic [DW-1:0]  bus_rdata
);
    kind_t          kind_q;
    logic [WAW-1:0] word_q;
    logic [DW-1:0]  wdata_q;
    logic           wr_q;
    logic           accept, in_second, first_done, last_done;
    lane_t          lanes;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= K_BYTE_EVEN;
            word_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            kind_q  <= classify(core_wide, core_addr[0]);
            word_q  <= core_addr[AW-1:1];
            wdata_q <= core_wdata;
            wr_q    <= core_wr;
        end
    end

    lane_splitter_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .core_req   (core_req),
        .bus_done   (bus_done),
        .is_split   (kind_q == K_WORD_SPLIT),
        .accept     (accept),
        .in_second  (in_second),
        .bus_req    (bus_req),
        .resp       (core_done),
        .first_done (first_done),
        .last_done  (last_done)
    );

    lane_splitter_decode #(.AW(AW), .BW(BW)) u_dec (
        .kind      (kind_q),
        .word_addr (word_q),
        .wdata     (wdata_q),
        .second    (in_second),
        .bus_waddr (bus_waddr),
        .lanes     (lanes),
        .bus_wdata (bus_wdata)
    );

    lane_splitter_merge #(.BW(BW)) u_mrg (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind_q),
        .first_done (first_done),
        .last_done  (last_done),
        .bus_rdata  (bus_rdata),
        .result     (core_rdata)
    );

    assign bus_bhe_n = lanes.bhe_n;
    assign bus_a0    = lanes.a0;
    assign bus_wr    = wr_q;
endmodule

// File: rtl/lane_splitter_chk.sv
module lane_splitter_chk #(
    parameter int AW = 20,
    localparam int WAW = AW - 1
) (
    input logic           clk,
    input logic           rst,
    input logic           core_req,
    input logic           core_wide,
    input logic           core_addr0,
    input logic           core_done,
    input logic           bus_req,
    input logic           bus_wr,
    input logic [WAW-1:0] bus_waddr,
    input logic           bus_bhe_n,
    input logic           bus_a0,
    input logic           bus_done
);
    logic busy;
    logic split_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            split_q <= 1'b0;
        end else if (!busy && core_req) begin
            busy    <= 1'b1;
            split_q <= core_wide && core_addr0;
        end else if (core_done) begin
            busy    <= 1'b0;
        end
    end

    // R12
    no_dead_lane_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !(bus_bhe_n && bus_a0));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_waddr) && $stable(bus_bhe_n)
                                    && $stable(bus_a0) && $stable(bus_wr)));

    // R10
    done_after_bus_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |-> $past(bus_done));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |=> !core_done);

    // R11
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (core_req && !busy) |=> bus_req);

    // R5
    split_second_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && split_q && bus_req && bus_a0 && bus_done) |=>
            (bus_req && !bus_a0 && bus_bhe_n && bus_waddr == WAW'($past(bus_waddr) + 1'b1)));
endmodule

bind lane_splitter lane_splitter_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_req   (core_req),
    .core_wide  (core_wide),
    .core_addr0 (core_addr[0]),
    .core_done  (core_done),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_waddr  (bus_waddr),
    .bus_bhe_n  (bus_bhe_n),
    .bus_a0     (bus_a0),
    .bus_done   (bus_done)
);

// File: tb/sim_lane_splitter.sv
module sim_lane_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int WAW = AW - 1;
    localparam int WMASK = (1 << WAW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_req = 1'b0, core_wr = 1'b0, core_wide = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic        core_done;
    logic [15:0] core_rdata;
    logic        bus_req, bus_wr, bus_bhe_n, bus_a0;
    logic [WAW-1:0] bus_waddr;
    logic [15:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata = '0;

    int vectors = 0;
    int fails = 0;
    int lat_cur = 0;
    int lat_cnt = 0;
    int cycles = 0;

    // Reference model state: 0 idle, 1 first bus cycle, 2 second bus cycle, 3 done cycle
    int m_phase = 0;
    int m_wr = 0, m_wide = 0, m_addr = 0, m_wdata = 0, m_res = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_splitter u0 (
        .clk(clk), .rst(rst), .core_req(core_req), .core_wr(core_wr), .core_wide(core_wide),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
        .core_rdata(core_rdata), .bus_req(bus_req), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_bhe_n(bus_bhe_n), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata)
    );

    // Memory contents seen by the bus engine: a fixed function of the word address
    function automatic logic [15:0] word_fn(input int wa);
        logic [7:0] hi, lo;
        hi = 8'(wa * 7 + 3) ^ 8'hA5;
        lo = 8'(wa * 13 + 1);
        return {hi, lo};
    endfunction

    function automatic string tag_of();
        if (m_wide == 0) return (m_addr % 2 == 0) ? "R2" : "R3";
        if (m_addr % 2 == 0) return "R4";
        if ((m_addr >> 1) == WMASK) return "R6";
        return "R5";
    endfunction

    task automatic check(input string rq, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Model advance on the clock edge (inputs are stable there)
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (core_req) begin // R11: requests in other phases are dropped
                    m_phase = 1; m_wr = core_wr; m_wide = core_wide;
                    m_addr = core_addr; m_wdata = core_wdata;
                end
                1: if (bus_done) begin
                    if (m_wide == 1 && m_addr % 2 == 1) m_phase = 2;
                    else begin
                        if (m_wide == 0) m_res = (m_addr % 2 == 0) ? word_fn(m_addr >> 1) & 'hFF
                                                                   : (word_fn(m_addr >> 1) >> 8) & 'hFF;
                        else m_res = word_fn(m_addr >> 1);
                        m_phase = 3;
                    end
                end
                2: if (bus_done) begin
                    m_res = ((word_fn(((m_addr >> 1) + 1) & WMASK) & 'hFF) << 8)
                          | ((word_fn(m_addr >> 1) >> 8) & 'hFF);
                    m_phase = 3;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // Per-cycle comparison, then the bus engine response, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int exp_wa, exp_lane, exp_wd, lo, hi;
            string t;
            t  = tag_of();
            lo = m_wdata & 'hFF;
            hi = (m_wdata >> 8) & 'hFF;
            check("R9", "bus_req", int'(bus_req), (m_phase == 1 || m_phase == 2) ? 1 : 0);
            check("R10", "core_done", int'(core_done), (m_phase == 3) ? 1 : 0);
            // R12: lane code 1,1 never on the bus
            if (bus_req) check("R12", "lane code", int'(bus_bhe_n && bus_a0), 0);
            if (m_phase == 1 || m_phase == 2) begin
                exp_wa = (m_phase == 1) ? (m_addr >> 1) : (((m_addr >> 1) + 1) & WMASK);
                if (m_wide == 1 && m_addr % 2 == 0) exp_lane = 0;
                else if (m_phase == 2 || m_addr % 2 == 0) exp_lane = 2;
                else exp_lane = 1;
                if (m_wide == 1 && m_addr % 2 == 0) exp_wd = m_wdata;
                else if (m_phase == 2) exp_wd = (hi << 8) | hi;
                else exp_wd = (lo << 8) | lo;
                check(t, "bus_waddr", int'(bus_waddr), exp_wa);
                check(t, "lanes {bhe_n,a0}", int'({bus_bhe_n, bus_a0}), exp_lane);
                check(t, "bus_wr", int'(bus_wr), m_wr);
                if (m_wr == 1) check(t, "bus_wdata", int'(bus_wdata), exp_wd);
            end
            if (m_phase == 3 && m_wr == 0)
                check((m_wide == 1 && m_addr % 2 == 1) ? "R8" : "R7", "core_rdata",
                      int'(core_rdata), m_res);
        end
        // Bus engine: done after lat_cur waiting cycles
        if (!rst && bus_req) begin
            if (lat_cnt >= lat_cur) begin
                bus_done  <= 1'b1;
                bus_rdata <= word_fn(int'(bus_waddr));
                lat_cnt = 0;
            end else begin
                bus_done <= 1'b0;
                lat_cnt++;
            end
        end else begin
            bus_done <= 1'b0;
            lat_cnt = 0;
        end
    end

    task automatic access(input logic wr, input logic wide, input int addr, input int wd,
                          input int lat, input bit stray);
        @(negedge clk);
        lat_cur    = lat;
        core_req   = 1'b1; core_wr = wr; core_wide = wide;
        core_addr  = AW'(addr); core_wdata = 16'(wd);
        @(negedge clk);
        core_req   = 1'b0;
        if (stray) begin
            // R11: a second request during the access must change nothing
            @(negedge clk);
            core_req = 1'b1; core_wr = ~wr; core_wide = 1'b1; core_addr = AW'(addr + 6);
            core_wdata = 16'hDEAD;
            @(negedge clk);
            core_req = 1'b0;
        end
        while (!core_done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "bus_req in reset", int'(bus_req), 0);
        check("R1", "core_done in reset", int'(core_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "bus_req after reset", int'(bus_req), 0);
        check("R1", "core_done after reset", int'(core_done), 0);

        // R2 / R3 byte accesses
        access(1'b0, 1'b0, 'h1234, 0, 0, 0);
        access(1'b0, 1'b0, 'h1235, 0, 1, 0);
        access(1'b1, 1'b0, 'h0040, 'h77C3, 2, 0);
        access(1'b1, 1'b0, 'h0041, 'h77C3, 0, 0);
        // R4 aligned word
        access(1'b0, 1'b1, 'h0A0A, 0, 1, 0);
        access(1'b1, 1'b1, 'h0A0C, 'hBEEF, 0, 0);
        // R5 / R8 split word, various latencies
        access(1'b0, 1'b1, 'h0A0D, 0, 0, 0);
        access(1'b0, 1'b1, 'h3333, 0, 3, 0);
        access(1'b1, 1'b1, 'h0A0F, 'h1281, 2, 0);
        // R6 wrap at the top word
        access(1'b0, 1'b1, 'hFFFFF, 0, 1, 0);
        access(1'b1, 1'b1, 'hFFFFF, 'hA55A, 0, 0);
        access(1'b0, 1'b0, 'hFFFFF, 0, 0, 0);
        // R11 stray requests while busy, incl. during a split
        access(1'b0, 1'b1, 'h0101, 0, 3, 1);
        access(1'b1, 1'b0, 'h0202, 'h0099, 3, 1);
        access(1'b1, 1'b1, 'h0300, 'h4321, 3, 1);
        // Back-to-back sweep over kinds and latencies
        for (int i = 0; i < 24; i++)
            access(logic'(i % 2), logic'((i / 2) % 2), 'h500 + i * 3, 'h1111 * i, i % 4, 0);
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule